// File: doc/BRIEF.md
# Single-Channel DAC Command Decoder and Register File

This block sits behind a serial shift front-end of a 16-bit voltage DAC. When a chip-select window closes, the front-end presents the last 24 bits it received: an 8-bit command in the top byte and a 16-bit payload below it. It also says whether at least 24 bits arrived. The block decodes the word and keeps three registers. A staged (preload) code and a live (output) code form a two-stage pair, and a small configuration register holds a write-block flag and two power-down selects. The live code drives the converter. The configuration drives an amplifier enable and the choice of output termination.

Three level-sensitive pins act directly on the registers. A load pin, active low, keeps the live code equal to the staged code. A clear pin, active low, holds every register at its default. A mid-scale select picks whether that default code is zero or half scale. Read commands do not answer at once. They load a 24-bit word into the front-end's shift register, and the host clocks that word out during its next transaction. Only channel 0 exists, and the amplifier and resistor ladder are outside this block.

Top module: `dac_cmd_regs`

## Requirements
- R1: After reset, both data registers hold 0000h when `mid_sel` is 0 or 8000h when it is 1, write-block is on, and the output is active (`amp_en`=1, both terminations 0), so a config read returns 0004h.
- R2: WR (08h) with write-block on loads only the staged register; `dac_code` keeps its value.
- R3: WR (08h) with write-block off loads both registers; `dac_code` shows the payload one clock after the frame.
- R4: WRUP (10h) and WRAL (20h) load both registers whatever the mode.
- R5: LDAC (18h) with payload bit 0 set copies the staged code to `dac_code`; with bit 0 clear it changes nothing.
- R6: SWB (28h) sets write-block from payload bit 0 (1 = block, 0 = through).
- R7: PD (30h) sets the power-down state. Bit 0 selects the pull-down termination and wins over bit 8, which selects high impedance. With both bits clear the output returns to active. Exactly one of `amp_en`, `term_pulldown`, `term_hiz` is high, and the config read bits are [2]=write-block, [1]=pull-down, [0]=high-Z.
- R8: While `ldac_n` is low, `dac_code` equals the staged code one clock after any change to it, including the frame that wrote it.
- R9: While `clr_n` is low, all registers take their R1 defaults at every clock, and the clear wins over a write in the same cycle.
- R10: RDDO (88h), RDIN (98h) and RDCO (90h) pulse `rdbk_valid` for one clock with `rdbk_word` = {command byte, staged / live / config value}, leave every register unchanged, and other commands do not pulse it.
- R11: Write and read commands whose low three command bits are not 000, reserved 80h–87h and any unlisted byte change nothing and produce no read-back.
- R12: A frame ended with `frame_full` low, and NOP (00h), change no register.
- R13: CLR (01h) returns all registers to the R1 defaults, using `mid_sel` at that moment.
- R14: During power-down, frames still decode and the registers still update; only `amp_en` and the terminations reflect the power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_end | input | 1 | One-cycle strobe: chip-select window closed |
| frame_full | input | 1 | At least 24 bits were received in that window |
| frame_word | input | 24 | Last 24 bits received, command in [23:16] |
| ldac_n | input | 1 | Level load: live code follows staged code while low |
| clr_n | input | 1 | Level clear: registers held at defaults while low |
| mid_sel | input | 1 | Default code select: 0 = zero, 1 = half scale |
| dac_code | output | 16 | Live code for the converter |
| amp_en | output | 1 | Output amplifier enabled |
| term_pulldown | output | 1 | Powered down with pull-down termination |
| term_hiz | output | 1 | Powered down with high-impedance output |
| rdbk_valid | output | 1 | One-cycle load strobe for the read-back word |
| rdbk_word | output | 24 | Word for the front-end shift register |

## Verification
On every clock, the bound checker confirms the following. The power-state outputs stay one-hot. A held clear yields the default code. A held load keeps the live code equal to the staged code. Read-back words always carry a read command. The live code holds still across aborted frames, blocked writes and writes to the wrong channel. The directed scenarios are what show the values that actually move. These include each write command's effect in both modes, the priority between the two power-down encodings, the two-transaction read-back contents of each register, the clear winning over a simultaneous write, and the choice of default code made by the mid-scale select.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  localparam int CMD_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLR,
    OP_LOAD,
    OP_MODE,
    OP_PDWN,
    OP_WR,
    OP_WRUP,
    OP_WRAL,
    OP_RD_PRE,
    OP_RD_CFG,
    OP_RD_OUT
  } op_e;

  typedef struct packed {
    logic wblk;
    logic sel_pd;
    logic sel_hiz;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{wblk: 1'b1, sel_pd: 1'b0, sel_hiz: 1'b0};

  // Map a command byte to an operation; a nonzero channel field yields OP_NONE.
  function automatic op_e classify(input logic [CMD_W-1:0] cmd);
    op_e r;
    r = OP_NONE;
    case (cmd)
      8'h01: r = OP_CLR;
      8'h18: r = OP_LOAD;
      8'h28: r = OP_MODE;
      8'h30: r = OP_PDWN;
      8'h20: r = OP_WRAL;
      default: begin
        if (cmd[ADDR_W-1:0] == '0) begin
          case (cmd[CMD_W-1:ADDR_W])
            5'b00001: r = OP_WR;
            5'b00010: r = OP_WRUP;
            5'b10001: r = OP_RD_PRE;
            5'b10010: r = OP_RD_CFG;
            5'b10011: r = OP_RD_OUT;
            default:  r = OP_NONE;
          endcase
        end
      end
    endcase
    return r;
  endfunction

  // Power-down select: pull-down bit wins over high-Z bit.
  function automatic cfg_t apply_pdwn(input cfg_t cur, input logic hiz_bit,
                                      input logic pd_bit);
    cfg_t n;
    n = cur;
    n.sel_pd  = pd_bit;
    n.sel_hiz = hiz_bit & ~pd_bit;
    return n;
  endfunction

  function automatic logic is_read(input op_e op);
    return (op == OP_RD_PRE) || (op == OP_RD_CFG) || (op == OP_RD_OUT);
  endfunction

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int FRAME_W = CMD_W + DATA_W
) (
  input  logic               frame_end,
  input  logic               frame_full,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               accept,
  output op_e                op,
  output logic [CMD_W-1:0]   cmd,
  output logic [DATA_W-1:0]  payload
);

  assign accept  = frame_end & frame_full;
  assign cmd     = frame_word[FRAME_W-1 -: CMD_W];
  assign payload = frame_word[DATA_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (accept) op = classify(cmd);
  end

endmodule

// File: rtl/dac_cfg_reg.sv
module dac_cfg_reg
  import dac_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  op_e  op,
  input  logic arg_lo,
  input  logic arg_hiz,
  output cfg_t cfg_q
);

  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (clear) begin
      cfg_d = CFG_DEFAULT;
    end else begin
      case (op)
        OP_MODE: cfg_d.wblk = arg_lo;
        OP_PDWN: cfg_d = apply_pdwn(cfg_q, arg_hiz, arg_lo);
        default: cfg_d = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_DEFAULT;
    else        cfg_q <= cfg_d;
  end

endmodule

// File: rtl/dac_data_regs.sv
module dac_data_regs
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              mid_sel,
  input  logic              ldac_n,
  input  op_e               op,
  input  logic              wblk,
  input  logic [DATA_W-1:0] payload,
  output logic [DATA_W-1:0] pre_q,
  output logic [DATA_W-1:0] out_q,
  output logic              wr_pre,
  output logic              wr_both,
  output logic              copy_evt
);

  function automatic logic [DATA_W-1:0] default_code(input logic mid);
    logic [DATA_W-1:0] c;
    c = '0;
    c[DATA_W-1] = mid;
    return c;
  endfunction

  logic [DATA_W-1:0] pre_d, out_d;
  logic              load_cmd;

  assign wr_both  = (op == OP_WRUP) || (op == OP_WRAL) || ((op == OP_WR) && !wblk);
  assign wr_pre   = wr_both || (op == OP_WR);
  assign load_cmd = (op == OP_LOAD) && payload[0];
  assign copy_evt = load_cmd || !ldac_n;

  always_comb begin
    pre_d = pre_q;
    out_d = out_q;
    if (clear) begin
      pre_d = default_code(mid_sel);
      out_d = default_code(mid_sel);
    end else begin
      if (wr_pre) pre_d = payload;
      if (wr_both)       out_d = payload;
      else if (copy_evt) out_d = pre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= default_code(mid_sel);
      out_q <= default_code(mid_sel);
    end else begin
      pre_q <= pre_d;
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/dac_readback.sv
module dac_readback
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int FRAME_W = CMD_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  op_e                op,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [DATA_W-1:0]  pre_q,
  input  logic [DATA_W-1:0]  out_q,
  input  cfg_t               cfg_q,
  output logic               rdbk_valid,
  output logic [FRAME_W-1:0] rdbk_word
);

  logic [DATA_W-1:0] sel_data;

  always_comb begin
    sel_data = '0;
    case (op)
      OP_RD_PRE: sel_data = pre_q;
      OP_RD_OUT: sel_data = out_q;
      OP_RD_CFG: sel_data[2:0] = cfg_q;
      default:   sel_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdbk_valid <= 1'b0;
      rdbk_word  <= '0;
    end else begin
      rdbk_valid <= is_read(op);
      if (is_read(op)) rdbk_word <= {cmd, sel_data};
    end
  end

endmodule

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int FRAME_W = CMD_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic               frame_full,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic               ldac_n,
  input  logic               clr_n,
  input  logic               mid_sel,
  output logic [DATA_W-1:0]  dac_code,
  output logic               amp_en,
  output logic               term_pulldown,
  output logic               term_hiz,
  output logic               rdbk_valid,
  output logic [FRAME_W-1:0] rdbk_word
);

  logic              cmd_accept;
  op_e               op;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] payload;
  logic              clear_evt;
  cfg_t              cfg_q;
  logic              wblk_q;
  logic [DATA_W-1:0] pre_q, out_q;
  logic              wr_pre_evt, wr_both_evt, copy_evt;

  dac_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .frame_end (frame_end),
    .frame_full(frame_full),
    .frame_word(frame_word),
    .accept    (cmd_accept),
    .op        (op),
    .cmd       (cmd),
    .payload   (payload)
  );

  assign clear_evt = !clr_n || (op == OP_CLR);

  dac_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear_evt),
    .op     (op),
    .arg_lo (payload[0]),
    .arg_hiz(payload[DATA_W/2]),
    .cfg_q  (cfg_q)
  );

  assign wblk_q = cfg_q.wblk;

  dac_data_regs #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_evt),
    .mid_sel (mid_sel),
    .ldac_n  (ldac_n),
    .op      (op),
    .wblk    (wblk_q),
    .payload (payload),
    .pre_q   (pre_q),
    .out_q   (out_q),
    .wr_pre  (wr_pre_evt),
    .wr_both (wr_both_evt),
    .copy_evt(copy_evt)
  );

  dac_readback #(.DATA_W(DATA_W)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .cmd       (cmd),
    .pre_q     (pre_q),
    .out_q     (out_q),
    .cfg_q     (cfg_q),
    .rdbk_valid(rdbk_valid),
    .rdbk_word (rdbk_word)
  );

  assign dac_code      = out_q;
  assign term_pulldown = cfg_q.sel_pd;
  assign term_hiz      = cfg_q.sel_hiz;
  assign amp_en        = ~(cfg_q.sel_pd | cfg_q.sel_hiz);

endmodule

// File: rtl/dac_cmd_regs_chk.sv
module dac_cmd_regs_chk #(
  parameter int DATA_W = 16,
  localparam int FRAME_W = 8 + DATA_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_end,
  input logic               frame_full,
  input logic [FRAME_W-1:0] frame_word,
  input logic               ldac_n,
  input logic               clr_n,
  input logic               mid_sel,
  input logic [DATA_W-1:0]  dac_code,
  input logic               amp_en,
  input logic               term_pulldown,
  input logic               term_hiz,
  input logic               rdbk_valid,
  input logic [FRAME_W-1:0] rdbk_word,
  input logic [DATA_W-1:0]  pre_q,
  input logic               wblk_q
);

  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic       acc;
  logic [7:0] c;
  assign acc = frame_end && frame_full;
  assign c   = frame_word[FRAME_W-1 -: 8];

  // R7: exactly one power state is presented
  a_r7_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({amp_en, term_pulldown, term_hiz}) == 1);

  // R9: a held clear yields the default code
  a_r9_clear_default: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> dac_code == ($past(mid_sel) ? MID : '0));

  // R8: held load keeps live code equal to staged code
  a_r8_load_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_n && clr_n) |=> dac_code == pre_q);

  // R10: read-back words carry a read command
  a_r10_read_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    rdbk_valid |-> rdbk_word[FRAME_W-1]);

  // R12: aborted frame leaves the live code alone
  a_r12_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_full && ldac_n && clr_n) |=> $stable(dac_code));

  // R2: blocked WR does not touch the live code
  a_r2_block_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && c == 8'h08 && wblk_q && ldac_n && clr_n) |=> $stable(dac_code));

  // R11: write to a foreign channel is ignored
  a_r11_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && c[7:3] == 5'b00001 && c[2:0] != 3'b000 && ldac_n && clr_n)
      |=> $stable(dac_code));

endmodule

bind dac_cmd_regs dac_cmd_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_end    (frame_end),
  .frame_full   (frame_full),
  .frame_word   (frame_word),
  .ldac_n       (ldac_n),
  .clr_n        (clr_n),
  .mid_sel      (mid_sel),
  .dac_code     (dac_code),
  .amp_en       (amp_en),
  .term_pulldown(term_pulldown),
  .term_hiz     (term_hiz),
  .rdbk_valid   (rdbk_valid),
  .rdbk_word    (rdbk_word),
  .pre_q        (pre_q),
  .wblk_q       (wblk_q)
);

// File: tb/dac_cmd_regs_test.sv
`timescale 1ns/1ps
module dac_cmd_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_end = 1'b0;
  logic        frame_full = 1'b0;
  logic [23:0] frame_word = '0;
  logic        ldac_n = 1'b1;
  logic        clr_n = 1'b1;
  logic        mid_sel = 1'b0;
  logic [15:0] dac_code;
  logic        amp_en, term_pulldown, term_hiz, rdbk_valid;
  logic [23:0] rdbk_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_cmd_regs uut (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_full(frame_full),
    .frame_word(frame_word), .ldac_n(ldac_n), .clr_n(clr_n), .mid_sel(mid_sel),
    .dac_code(dac_code), .amp_en(amp_en), .term_pulldown(term_pulldown),
    .term_hiz(term_hiz), .rdbk_valid(rdbk_valid), .rdbk_word(rdbk_word)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Frame presented for one cycle; returns at the falling edge after the update.
  task automatic send(input logic [7:0] c, input logic [15:0] p, input bit full = 1'b1);
    @(negedge clk);
    frame_end = 1'b1; frame_full = full; frame_word = {c, p};
    @(negedge clk);
    frame_end = 1'b0; frame_full = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] c, input string tag, input logic [15:0] exp);
    send(c, 16'h0000);
    check({tag, " valid"}, {23'd0, rdbk_valid}, 24'd1);
    check({tag, " word"}, rdbk_word, {c, exp});
  endtask

  task automatic do_reset(input bit mid);
    @(negedge clk);
    mid_sel = mid; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pwr(input string tag, input bit a, input bit pd, input bit hz);
    check({tag, " amp"}, {23'd0, amp_en}, {23'd0, a});
    check({tag, " pd"}, {23'd0, term_pulldown}, {23'd0, pd});
    check({tag, " hiz"}, {23'd0, term_hiz}, {23'd0, hz});
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R1 code zero", {8'd0, dac_code}, 24'h000000);
    pwr("R1", 1'b1, 1'b0, 1'b0);
    read_reg(8'h90, "R1 cfg", 16'h0004);
  endtask

  task automatic t_block_write;
    send(8'h08, 16'h4000);
    check("R2 code held", {8'd0, dac_code}, 24'h000000);
    check("R10 no rdbk on write", {23'd0, rdbk_valid}, 24'd0);
    read_reg(8'h88, "R2 pre", 16'h4000);
    read_reg(8'h98, "R10 out", 16'h0000);
    check("R10 read no change", {8'd0, dac_code}, 24'h000000);
  endtask

  task automatic t_load_cmd;
    send(8'h18, 16'h0000);
    check("R5 bit0 clear", {8'd0, dac_code}, 24'h000000);
    send(8'h18, 16'h0001);
    check("R5 copy", {8'd0, dac_code}, 24'h004000);
  endtask

  task automatic t_mode;
    send(8'h28, 16'h0000);
    read_reg(8'h90, "R6 through", 16'h0000);
    send(8'h08, 16'h1234);
    check("R3 write through", {8'd0, dac_code}, 24'h001234);
    send(8'h28, 16'h0001);
    read_reg(8'h90, "R6 block", 16'h0004);
  endtask

  task automatic t_direct_writes;
    send(8'h10, 16'hABCD);
    check("R4 wrup", {8'd0, dac_code}, 24'h00ABCD);
    send(8'h20, 16'h5555);
    check("R4 wral", {8'd0, dac_code}, 24'h005555);
    read_reg(8'h88, "R4 pre", 16'h5555);
  endtask

  task automatic t_ignored;
    send(8'h11, 16'h1111);
    check("R11 chan1 wrup", {8'd0, dac_code}, 24'h005555);
    send(8'h82, 16'h2222);
    check("R11 reserved no rdbk", {23'd0, rdbk_valid}, 24'd0);
    send(8'h89, 16'h0000);
    check("R11 chan1 read", {23'd0, rdbk_valid}, 24'd0);
    send(8'h7E, 16'h3333);
    check("R11 unknown", {8'd0, dac_code}, 24'h005555);
    read_reg(8'h88, "R11 pre kept", 16'h5555);
  endtask

  task automatic t_abort_nop;
    send(8'h10, 16'h7777, 1'b0);
    check("R12 abort", {8'd0, dac_code}, 24'h005555);
    send(8'h00, 16'hFFFF);
    check("R12 nop", {8'd0, dac_code}, 24'h005555);
    read_reg(8'h88, "R12 pre kept", 16'h5555);
  endtask

  task automatic t_pdwn;
    send(8'h30, 16'h0100);
    pwr("R7 hiz", 1'b0, 1'b0, 1'b1);
    read_reg(8'h90, "R7 cfg hiz", 16'h0005);
    send(8'h30, 16'h0101);
    pwr("R7 both", 1'b0, 1'b1, 1'b0);
    send(8'h10, 16'h2222);
    check("R14 write in pd", {8'd0, dac_code}, 24'h002222);
    pwr("R14 still pd", 1'b0, 1'b1, 1'b0);
    read_reg(8'h90, "R7 cfg pd", 16'h0006);
    send(8'h30, 16'h0000);
    pwr("R7 active", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_ldac_pin;
    @(negedge clk); ldac_n = 1'b0;
    send(8'h08, 16'h3333);
    check("R8 follow", {8'd0, dac_code}, 24'h003333);
    @(negedge clk); ldac_n = 1'b1;
    send(8'h08, 16'h4444);
    check("R8 released", {8'd0, dac_code}, 24'h003333);
  endtask

  task automatic t_clr_pin;
    send(8'h28, 16'h0000);
    send(8'h30, 16'h0001);
    @(negedge clk); clr_n = 1'b0;
    send(8'h10, 16'h9999);
    check("R9 clear beats write", {8'd0, dac_code}, 24'h000000);
    send(8'h10, 16'h8888);
    check("R9 clear held", {8'd0, dac_code}, 24'h000000);
    @(negedge clk); clr_n = 1'b1;
    pwr("R9", 1'b1, 1'b0, 1'b0);
    read_reg(8'h90, "R9 cfg", 16'h0004);
    read_reg(8'h88, "R9 pre", 16'h0000);
  endtask

  task automatic t_clr_cmd;
    send(8'h10, 16'h1234);
    @(negedge clk); mid_sel = 1'b1;
    send(8'h01, 16'h0000);
    check("R13 clear mid", {8'd0, dac_code}, 24'h008000);
    read_reg(8'h88, "R13 pre", 16'h8000);
  endtask

  task automatic t_reset_mid;
    do_reset(1'b1);
    check("R1 code mid", {8'd0, dac_code}, 24'h008000);
    read_reg(8'h98, "R1 out mid", 16'h8000);
  endtask

  initial begin
    t_reset();
    t_block_write();
    t_load_cmd();
    t_mode();
    t_direct_writes();
    t_ignored();
    t_abort_nop();
    t_pdwn();
    t_ldac_pin();
    t_clr_pin();
    t_clr_cmd();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule